// File: doc/BRIEF.md
# Cached-Credit Command Issuer

This block sits between a command producer and a downstream command queue that is reached over a bus. The producer asks to send a group of N command words. The issuer keeps a local credit: a pessimistic count of the free entries in the queue. When the credit covers the group, the issuer subtracts N and streams the words out with no status traffic. When the credit is short, the issuer reads the queue's status register and loads the reported free count as the new credit. It then checks again, and keeps reading until the group fits, with a fixed pause between reads.

The queue only drains between a status read and the writes that follow it, so the credit is always at or below the true free count. The issuer therefore never pushes a word into a full queue. Under steady filling, it still reads status only about once per queue-depth worth of words. The credit starts at zero after reset, so the first group always causes a read. A 16-bit counter of completed status reads is exposed so that the read rate can be observed.

Top module: `cmd_credit_issuer`

## Requirements
- R1: After reset, the block is in the following state:
  - `req_ready` is 1.
  - `req_err`, `wr_valid`, `word_ready` and `st_rd_req` are 0.
  - `status_reads` is 0.
  - The credit is 0, so the first accepted group causes exactly one status read before any word is written.
- R2: Status reads follow this handshake:
  - `st_rd_req` stays high until `st_rd_done` is seen high in the same cycle.
  - In that cycle, `st_rd_free` (clamped to DEPTH) replaces the credit.
  - In that cycle, `status_reads` increases by one.
- R3: A group whose size is at most the current credit is issued with no status read. The credit then drops by the group size, so following groups that fit in the rest also need no read.
- R4: When the credit is still short after a status read, the next read starts only after a pause. `st_rd_req` stays low for exactly RETRY_GAP+1 cycles between the two reads. Reads repeat until the credit covers the group.
- R5: The words written since any status read never exceed the free count that read returned. A queue that only drains therefore never receives a word while full.
- R6: A request with `req_count` equal to 0 or greater than DEPTH is handled as follows:
  - The handshake still completes.
  - `req_err` is 1 for exactly the one cycle after the handshake.
  - No word is written and no status read is made.
  - `req_ready` is 1 again in that same cycle.
  - A count of exactly DEPTH is accepted.
- R7: During a granted group:
  - `wr_valid` follows `word_valid`, `wr_data` follows `word_data`, and `word_ready` follows `wr_ready`, all in the same cycle.
  - Exactly `req_count` words are passed on, in order.
  - `word_ready` is 0 outside a group.
- R8: `req_ready` is 0 from the cycle after a valid request is accepted until the last word of its group is accepted. It is 1 in the cycle right after that last word.
- R9: With DEPTH=256, an empty queue, no draining, and back-to-back groups of 8 words, 256 words are issued with exactly one status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Group request present |
| req_count | input | CW | Number of words in the group (CW = clog2(DEPTH+1)) |
| req_ready | output | 1 | Issuer can take a request |
| req_err | output | 1 | One-cycle pulse: last request had an illegal size |
| word_valid | input | 1 | Command word present on `word_data` |
| word_data | input | DW | Command word from the producer |
| word_ready | output | 1 | Command word taken this cycle |
| wr_valid | output | 1 | Write to the downstream queue |
| wr_data | output | DW | Word written to the downstream queue |
| wr_ready | input | 1 | Downstream write accepted |
| st_rd_req | output | 1 | Status read request |
| st_rd_done | input | 1 | Status read complete, `st_rd_free` valid |
| st_rd_free | input | CW | Free entries reported by the queue |
| status_reads | output | PERF_W | Count of completed status reads |

## Verification
Two functions meet in the same cycle: a queue drain, and the last status read before a group is granted. The bench provokes this by starting with a nearly full queue model that drains every few cycles while groups arrive back to back, with write backpressure applied. This means a read often returns just before more space frees up. The queue model flags any word written while it is full. A bound checker compares the words written since each read against that read's free count.

The second overlap is the last word of a group and the next request, which is already waiting. It is judged by checking that `req_ready` returns exactly one cycle after the final word handshake.

// File: rtl/cci_pkg.sv
package cci_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_READ  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_ISSUE = 3'd4
  } cci_state_e;

endpackage

// File: rtl/cci_rst_sync.sv
module cci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/cci_credit.sv
module cci_credit #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          take_en,
  input  logic [CW-1:0] need,
  output logic          enough
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] credit_q, credit_d;
  logic          credit_en;
  logic [CW-1:0] load_clamped;

  assign load_clamped = (load_val > CAP) ? CAP : load_val;
  assign credit_en    = load_en | take_en;

  always_comb begin
    credit_d = credit_q;
    if (load_en) begin
      credit_d = load_clamped;
    end else if (take_en) begin
      credit_d = credit_q - need;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else if (credit_en) begin
      credit_q <= credit_d;
    end
  end

  assign enough = (credit_q >= need);

endmodule

// File: rtl/cci_beat_count.sv
module cci_beat_count #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          beat,
  output logic [CW-1:0] remaining,
  output logic          last
);

  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en;

  assign rem_en = load_en | beat;

  always_comb begin
    rem_d = rem_q;
    if (load_en) begin
      rem_d = load_val;
    end else if (beat) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign remaining = rem_q;
  assign last      = (rem_q == CW'(1));

endmodule

// File: rtl/cci_retry_timer.sv
module cci_retry_timer #(
  parameter int RETRY_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  generate
    if (RETRY_GAP == 0) begin : g_nogap
      assign expired = 1'b1;
    end else begin : g_gap
      localparam int TW = $clog2(RETRY_GAP + 1);
      localparam logic [TW-1:0] LOADV = TW'(RETRY_GAP - 1);

      logic [TW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign cnt_en = start | (run & (cnt_q != '0));

      always_comb begin
        cnt_d = cnt_q;
        if (start) begin
          cnt_d = LOADV;
        end else if (run && cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign expired = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/cci_seq.sv
module cci_seq
  import cci_pkg::*;
#(
  parameter int RETRY_GAP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       count_ok,
  input  logic       enough,
  input  logic       rd_done,
  input  logic       gap_done,
  input  logic       beat,
  input  logic       last_beat,
  output cci_state_e state,
  output logic       accept,
  output logic       err_set,
  output logic       take,
  output logic       load,
  output logic       gap_start
);

  localparam bit HAS_GAP = (RETRY_GAP > 0);

  cci_state_e state_q, state_d;
  logic       retry_q, retry_d;

  always_comb begin
    state_d   = state_q;
    retry_d   = retry_q;
    accept    = 1'b0;
    err_set   = 1'b0;
    take      = 1'b0;
    load      = 1'b0;
    gap_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (count_ok) begin
            accept  = 1'b1;
            retry_d = 1'b0;
            state_d = ST_CHECK;
          end else begin
            err_set = 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (enough) begin
          take    = 1'b1;
          state_d = ST_ISSUE;
        end else if (retry_q && HAS_GAP) begin
          gap_start = 1'b1;
          state_d   = ST_WAIT;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (rd_done) begin
          load    = 1'b1;
          retry_d = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_WAIT: begin
        if (gap_done) begin
          state_d = ST_READ;
        end
      end
      ST_ISSUE: begin
        if (beat && last_beat) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/cmd_credit_issuer.sv
module cmd_credit_issuer
  import cci_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int DW        = 32,
  parameter int RETRY_GAP = 8,
  parameter int PERF_W    = 16,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CW-1:0]     req_count,
  output logic              req_ready,
  output logic              req_err,
  input  logic              word_valid,
  input  logic [DW-1:0]     word_data,
  output logic              word_ready,
  output logic              wr_valid,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_ready,
  output logic              st_rd_req,
  input  logic              st_rd_done,
  input  logic [CW-1:0]     st_rd_free,
  output logic [PERF_W-1:0] status_reads
);

  localparam logic [CW-1:0] MAXN = CW'(DEPTH);

  logic          rst_n_i;
  cci_state_e    state;
  logic          accept, err_set, take, load, gap_start;
  logic          enough, gap_done, last_beat, beat;
  logic          count_ok, in_issue, rd_done;
  logic [CW-1:0] need;
  logic          err_q;
  logic [PERF_W-1:0] reads_q;

  cci_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign count_ok = (req_count != '0) && (req_count <= MAXN);
  assign in_issue = (state == ST_ISSUE);
  assign rd_done  = (state == ST_READ) && st_rd_done;
  assign beat     = in_issue && word_valid && wr_ready;

  cci_seq #(.RETRY_GAP(RETRY_GAP)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .count_ok  (count_ok),
    .enough    (enough),
    .rd_done   (rd_done),
    .gap_done  (gap_done),
    .beat      (beat),
    .last_beat (last_beat),
    .state     (state),
    .accept    (accept),
    .err_set   (err_set),
    .take      (take),
    .load      (load),
    .gap_start (gap_start)
  );

  cci_credit #(.DEPTH(DEPTH), .CW(CW)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load_en  (load),
    .load_val (st_rd_free),
    .take_en  (take),
    .need     (need),
    .enough   (enough)
  );

  cci_beat_count #(.CW(CW)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load_en   (accept),
    .load_val  (req_count),
    .beat      (beat),
    .remaining (need),
    .last      (last_beat)
  );

  cci_retry_timer #(.RETRY_GAP(RETRY_GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (gap_start),
    .run     (state == ST_WAIT),
    .expired (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      reads_q <= '0;
    end else if (rd_done) begin
      reads_q <= reads_q + 1'b1;
    end
  end

  assign req_ready    = (state == ST_IDLE) && rst_n_i;
  assign req_err      = err_q;
  assign wr_valid     = in_issue && word_valid;
  assign wr_data      = word_data;
  assign word_ready   = in_issue && wr_ready;
  assign st_rd_req    = (state == ST_READ);
  assign status_reads = reads_q;

endmodule

// File: rtl/cci_issuer_checker.sv
module cci_issuer_checker #(
  parameter int DEPTH  = 256,
  parameter int PERF_W = 16,
  parameter int CW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CW-1:0]     req_count,
  input logic              req_ready,
  input logic              req_err,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              st_rd_req,
  input logic              st_rd_done,
  input logic [CW-1:0]     st_rd_free,
  input logic [PERF_W-1:0] status_reads
);

  logic          seen_q;
  logic [CW-1:0] cap_q, used_q;
  logic          good_req;

  assign good_req = (req_count != '0) && (req_count <= CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cap_q  <= '0;
      used_q <= '0;
    end else if (st_rd_req && st_rd_done) begin
      seen_q <= 1'b1;
      cap_q  <= (st_rd_free > CW'(DEPTH)) ? CW'(DEPTH) : st_rd_free;
      used_q <= '0;
    end else if (wr_valid && wr_ready) begin
      used_q <= used_q + 1'b1;
    end
  end

  // R2: read request held until completion
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_req && !st_rd_done) |=> st_rd_req);

  // R2: one count per completed read
  assert_read_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_req && st_rd_done) |=> (status_reads == $past(status_reads) + 1'b1));

  // R3: no status traffic while words are written
  assert_no_read_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !st_rd_req);

  // R5: writes since a read stay within the free count it returned
  assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (seen_q && (used_q < cap_q)));

  // R6: error pulse only after a handshake
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready && !good_req));

  // R8: busy after taking a legal request
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && good_req) |=> !req_ready);

endmodule

bind cmd_credit_issuer cci_issuer_checker #(
  .DEPTH (DEPTH),
  .PERF_W(PERF_W),
  .CW    (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_count    (req_count),
  .req_ready    (req_ready),
  .req_err      (req_err),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .st_rd_req    (st_rd_req),
  .st_rd_done   (st_rd_done),
  .st_rd_free   (st_rd_free),
  .status_reads (status_reads)
);

// File: tb/cmd_credit_issuer_tb_top.sv
`timescale 1ns/1ps
module cmd_credit_issuer_tb_top;

  localparam int DEPTH  = 256;
  localparam int DW     = 32;
  localparam int GAP    = 3;
  localparam int PERF_W = 16;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CW-1:0] req_count = '0;
  logic req_ready, req_err;
  logic word_valid = 1'b1;
  logic [DW-1:0] word_data = '0;
  logic word_ready, wr_valid;
  logic [DW-1:0] wr_data;
  logic wr_ready = 1'b1;
  logic st_rd_req;
  logic st_rd_done = 1'b0;
  logic [CW-1:0] st_rd_free = '0;
  logic [PERF_W-1:0] status_reads;

  always #5 clk = ~clk;

  cmd_credit_issuer #(
    .DEPTH(DEPTH), .DW(DW), .RETRY_GAP(GAP), .PERF_W(PERF_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
    .req_err(req_err),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .st_rd_req(st_rd_req), .st_rd_done(st_rd_done), .st_rd_free(st_rd_free),
    .status_reads(status_reads)
  );

  int checks = 0;
  int failures = 0;

  // bench model state
  int cyc = 0, seq = 0, occ = 0, words = 0, hs_cyc = 0;
  int reads_seen = 0, done_cyc = 0, lat = 0;
  int gap_good = 0, gap_bad = 0;
  bit pend = 0, rd_prev = 0, have_done = 0;
  bit drain_en = 0, bp_en = 0;
  int drain_per = 3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // queue model, word source and status responder
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        seq++;
        word_data = DW'(seq);
        pend = 0;
      end
      if (st_rd_done) st_rd_done = 1'b0;
      wr_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
      if (drain_en && (cyc % drain_per) == 0 && occ > 0) occ--;
      #1;
      if (wr_valid && wr_ready) begin
        pend = 1;
        hs_cyc = cyc;
        chk(occ < DEPTH, "R5 write into full queue", occ, DEPTH - 1);
        chk(wr_data == DW'(seq), "R7 word order", int'(wr_data), seq);
        chk(word_ready == 1'b1, "R7 word_ready on write", int'(word_ready), 1);
        occ++;
        words++;
      end
      if (st_rd_req && !st_rd_done) begin
        if (!rd_prev && have_done) begin
          if (cyc - done_cyc == GAP + 2) gap_good++;
          else gap_bad++;
        end
        lat++;
        if (lat >= 2) begin
          st_rd_done = 1'b1;
          st_rd_free = CW'(DEPTH - occ);
          done_cyc = cyc;
          reads_seen++;
          have_done = 1;
          lat = 0;
        end
      end
      rd_prev = st_rd_req;
    end
  end

  task automatic do_reset(input int start_occ);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    drain_en = 0;
    bp_en = 0;
    repeat (3) @(negedge clk);
    occ = start_occ;
    words = 0;
    reads_seen = 0;
    have_done = 0;
    gap_good = 0;
    gap_bad = 0;
    lat = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // present a request, return once the handshake edge has passed (at negedge+2)
  task automatic issue_req(input int n, output bit errd);
    @(negedge clk);
    req_valid = 1'b1;
    req_count = CW'(n);
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    errd = req_err;
  endtask

  task automatic wait_idle(input int n, input int w0, input string tag);
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    chk(cyc == hs_cyc + 1, {tag, " R8 ready after last word"}, cyc - hs_cyc, 1);
    chk(words - w0 == n, {tag, " R7 word count"}, words - w0, n);
  endtask

  task automatic send(input int n, input string tag);
    bit e;
    int w0;
    w0 = words;
    issue_req(n, e);
    chk(e == 1'b0, {tag, " R6 no error on legal size"}, int'(e), 0);
    wait_idle(n, w0, tag);
  endtask

  task automatic t_reset;
    do_reset(0);
    #2;
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(wr_valid == 1'b0 && word_ready == 1'b0, "R1 write idle",
        int'({wr_valid, word_ready}), 0);
    chk(st_rd_req == 1'b0, "R1 no read", int'(st_rd_req), 0);
    chk(status_reads == 0 && req_err == 1'b0, "R1 counter and error",
        int'(status_reads), 0);
  endtask

  task automatic t_basic;
    do_reset(0);
    send(8, "basic1");
    chk(reads_seen == 1, "R1 first group reads once", reads_seen, 1);
    chk(status_reads == 1, "R2 read counter", int'(status_reads), 1);
    send(5, "basic2");
    send(3, "basic3");
    chk(reads_seen == 1, "R3 no further read", reads_seen, 1);
    chk(status_reads == 1, "R3 counter unchanged", int'(status_reads), 1);
  endtask

  task automatic t_error;
    bit e;
    int w0;
    do_reset(0);
    issue_req(0, e);
    chk(e == 1'b1, "R6 zero size flagged", int'(e), 1);
    chk(req_ready == 1'b1, "R6 ready after error", int'(req_ready), 1);
    @(negedge clk); #2;
    chk(req_err == 1'b0, "R6 pulse one cycle", int'(req_err), 0);
    issue_req(DEPTH + 1, e);
    chk(e == 1'b1, "R6 oversize flagged", int'(e), 1);
    repeat (4) @(negedge clk);
    #2;
    chk(words == 0 && reads_seen == 0, "R6 nothing issued", words + reads_seen, 0);
    chk(status_reads == 0, "R6 counter untouched", int'(status_reads), 0);
    w0 = words;
    send(DEPTH, "full_group");
    chk(words - w0 == DEPTH, "R6 depth-size group accepted", words - w0, DEPTH);
  endtask

  task automatic t_fill;
    do_reset(0);
    for (int g = 0; g < DEPTH / 8; g++) send(8, "fill");
    chk(words == DEPTH, "R9 words issued", words, DEPTH);
    chk(reads_seen == 1, "R9 one read per depth", reads_seen, 1);
    chk(status_reads == 1, "R9 counter", int'(status_reads), 1);
  endtask

  task automatic t_retry;
    bit e;
    int w0;
    do_reset(DEPTH);
    w0 = words;
    issue_req(4, e);
    while (reads_seen < 3) @(negedge clk);
    chk(words == w0, "R4 no write while short", words - w0, 0);
    drain_per = 2;
    drain_en = 1;
    #2;
    wait_idle(4, w0, "retry");
    chk(gap_bad == 0, "R4 retry gap length", gap_bad, 0);
    chk(gap_good >= 2, "R4 retries observed", gap_good, 2);
    chk(int'(status_reads) == reads_seen, "R2 counter matches reads",
        int'(status_reads), reads_seen);
  endtask

  task automatic t_drain;
    do_reset(DEPTH - 10);
    drain_per = 3;
    drain_en = 1;
    bp_en = 1;
    for (int g = 0; g < 20; g++) send(6, "drain");
    chk(words == 120, "R5 all words delivered", words, 120);
    chk(reads_seen > 1, "R4 refreshes under drain", reads_seen, 2);
    chk(int'(status_reads) == reads_seen, "R2 counter under drain",
        int'(status_reads), reads_seen);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_error();
    t_fill();
    t_retry();
    t_drain();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule